// File: doc/BRIEF.md
# Quadrature Position Counter with Cascade

This block is a pair of 16-bit up/down counter channels for tracking the position of a rotary or linear encoder. The lower channel either decodes a two-phase quadrature signal, counting on every edge of both phases, or counts up on a plain one-cycle strobe. Phase A leading phase B by a quarter period counts up; B leading A counts down.

The upper channel either counts up on its own strobe or, in cascade mode, takes the lower channel's wraps as its count input. A wrap upward adds one to the upper counter and a wrap downward takes one away, so the pair reads as one signed 32-bit position `{cntHi, cntLo}`. Software can load either counter through a small write port and clears the wrap flags by writing ones to them.

The encoder phases are asynchronous. Each phase goes through a synchroniser before the edge is decoded. A step in which both phases change at once cannot be given a direction, so it is dropped.

Top module: `quad_cascade_counter`

## Requirements
- R1: After reset both counters read 0, all four flags read 0 and `dirUp` reads 1.
- R2: With `phaseEn`=1, each single-phase transition in the forward order AB = 00→10→11→01→00 adds 1 to `cntLo`. The new value first appears three rising edges after the input changes, and is not yet visible after two.
- R3: With `phaseEn`=1, each transition in the reverse order AB = 00→01→11→10→00 subtracts 1 from `cntLo`.
- R4: A transition in which A and B change together leaves every counter, flag and `dirUp` unchanged. The synchronised phase state still follows the inputs.
- R5: With `phaseEn`=0, the encoder inputs have no effect and `cntLo` adds 1 for each cycle in which `cntStrobeLo` is high. Turning `phaseEn` back on makes no count from encoder motion that happened while it was off.
- R6: With `cascadeEn`=1, a `cntLo` wrap from 0xFFFF to 0x0000 adds 1 to `cntHi`, and a wrap from 0x0000 to 0xFFFF subtracts 1 from it, on the same clock edge as the wrap. `{cntHi,cntLo}` then follows a 32-bit up/down count.
- R7: With `cascadeEn`=0, `cntHi` adds 1 for each cycle in which `cntStrobeHi` is high, and wraps of `cntLo` leave it untouched.
- R8: `flags` bit 0 sets when `cntLo` wraps upward, bit 1 when it wraps downward, bit 2 when `cntHi` wraps upward and bit 3 when `cntHi` wraps downward. A set flag stays set until a write with `regSel`=2 and a 1 in the matching `wrData` bit clears it. If a flag is set and cleared in the same cycle, the set takes effect.
- R9: A write with `regSel`=0 loads `cntLo` and a write with `regSel`=1 loads `cntHi`. Each write takes effect at the next edge and takes priority over a count to the same counter in that cycle. A write with `regSel`=3 changes nothing.
- R10: `dirUp` holds the direction of the most recent count applied to `cntLo` (1 = up, 0 = down). A plain strobe count counts as up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| encA | input | 1 | Encoder phase A, asynchronous |
| encB | input | 1 | Encoder phase B, asynchronous |
| phaseEn | input | 1 | Lower channel decodes the quadrature signal when 1 |
| cascadeEn | input | 1 | Upper channel counts lower-channel wraps when 1 |
| cntStrobeLo | input | 1 | Up-count strobe for the lower channel when not decoding phases |
| cntStrobeHi | input | 1 | Up-count strobe for the upper channel when not cascaded |
| wrEn | input | 1 | Write strobe |
| regSel | input | 2 | Write target: 0 lower count, 1 upper count, 2 flag clear, 3 none |
| wrData | input | 16 | Write data; bits 3:0 form the clear mask for regSel 2 |
| cntLo | output | 16 | Lower counter |
| cntHi | output | 16 | Upper counter |
| flags | output | 4 | Wrap flags {hiDown, hiUp, loDown, loUp} |
| dirUp | output | 1 | Direction of the latest lower count |

## Verification
A wrong decoded direction or a stale previous-phase register shows on `cntLo` and `dirUp` three edges after the encoder step that triggers it, so checking after every step pins the fault to that step. A cascade fault stays hidden until the lower counter wraps. For that reason the stimulus deliberately walks the 32-bit position back and forth across the 0xFFFF/0x0000 boundary, and at each crossing `cntHi` and the flags are compared with an arithmetic model. A flag that sets or clears wrongly stays wrong until the next explicit clear, so the flags are read after every wrap and after every clear.

// File: rtl/qcc_pkg.sv
package qcc_pkg;
  localparam int FLAG_W = 4;

  typedef struct packed {
    logic              loStep;
    logic              loUp;
    logic              hiStep;
    logic              wrLo;
    logic              wrHi;
    logic [FLAG_W-1:0] clrMask;
  } qcc_strobe_t;
endpackage

// File: rtl/qcc_ctrl.sv
module qcc_ctrl
  import qcc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              encA,
  input  logic              encB,
  input  logic              phaseEn,
  input  logic              cascadeEn,
  input  logic              cntStrobeLo,
  input  logic              cntStrobeHi,
  input  logic              wrEn,
  input  logic [1:0]        regSel,
  input  logic [FLAG_W-1:0] clrBits,
  output qcc_strobe_t       strobes
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncA, syncB;
  logic prevA, prevB;
  logic currA, currB;
  logic chgA, chgB, legalStep, phaseUp;

  // synchroniser chains; the last stage feeds the decoder
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevA <= 1'b0;
      prevB <= 1'b0;
    end else begin
      syncA <= {syncA[SYNC_STAGES-2:0], encA};
      syncB <= {syncB[SYNC_STAGES-2:0], encB};
      prevA <= syncA[LAST];
      prevB <= syncB[LAST];
    end
  end

  assign currA = syncA[LAST];
  assign currB = syncB[LAST];
  assign chgA  = currA ^ prevA;
  assign chgB  = currB ^ prevB;
  // exactly one phase moved: a decodable quarter step
  assign legalStep = chgA ^ chgB;
  // forward order has the old A equal to the new B
  assign phaseUp = ~(prevA ^ currB);

  always_comb begin
    strobes.loStep  = phaseEn ? legalStep : cntStrobeLo;
    strobes.loUp    = phaseEn ? phaseUp : 1'b1;
    strobes.hiStep  = ~cascadeEn & cntStrobeHi;
    strobes.wrLo    = wrEn && (regSel == 2'd0);
    strobes.wrHi    = wrEn && (regSel == 2'd1);
    strobes.clrMask = (wrEn && (regSel == 2'd2)) ? clrBits : '0;
  end

  // R5: with decoding off, only the plain strobe can make a lower count
  p_mode_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!phaseEn && !cntStrobeLo) |-> !strobes.loStep);

  // R4: a double change of the synchronised phases never yields a step
  p_illegal_drop_r4: assert property (@(posedge clk) disable iff (!rstN)
    (phaseEn && (currA != $past(currA)) && (currB != $past(currB))) |-> !strobes.loStep);
endmodule

// File: rtl/qcc_chan.sv
module qcc_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [CNT_W-1:0] loadVal,
  input  logic             step,
  input  logic             up,
  output logic [CNT_W-1:0] cnt,
  output logic             wrapUp,
  output logic             wrapDn
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic isMax, isZero, doStep;

  assign isMax  = (cnt == {CNT_W{1'b1}});
  assign isZero = (cnt == '0);
  assign doStep = step & ~load;
  assign wrapUp = doStep & up & isMax;
  assign wrapDn = doStep & ~up & isZero;

  always_ff @(posedge clk) begin
    if (!rstN)       cnt <= '0;
    else if (load)   cnt <= loadVal;
    else if (doStep) cnt <= up ? cnt + ONE : cnt - ONE;
  end

  // R9: a load always lands, whatever the step request
  p_load_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    load |=> cnt == $past(loadVal));
endmodule

// File: rtl/qcc_datapath.sv
module qcc_datapath
  import qcc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cascadeEn,
  input  qcc_strobe_t       strobes,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  cntLo,
  output logic [CNT_W-1:0]  cntHi,
  output logic [FLAG_W-1:0] flags,
  output logic              dirUp
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic loWrapUp, loWrapDn, hiWrapUp, hiWrapDn;
  logic hiStepEff, hiUpEff;
  logic [FLAG_W-1:0] setMask;

  qcc_chan #(.CNT_W(CNT_W)) u_lo (
    .clk(clk), .rstN(rstN),
    .load(strobes.wrLo), .loadVal(wrData),
    .step(strobes.loStep), .up(strobes.loUp),
    .cnt(cntLo), .wrapUp(loWrapUp), .wrapDn(loWrapDn)
  );

  // cascade: the lower channel's wraps become the upper channel's count input
  assign hiStepEff = cascadeEn ? (loWrapUp | loWrapDn) : strobes.hiStep;
  assign hiUpEff   = cascadeEn ? loWrapUp : 1'b1;

  qcc_chan #(.CNT_W(CNT_W)) u_hi (
    .clk(clk), .rstN(rstN),
    .load(strobes.wrHi), .loadVal(wrData),
    .step(hiStepEff), .up(hiUpEff),
    .cnt(cntHi), .wrapUp(hiWrapUp), .wrapDn(hiWrapDn)
  );

  assign setMask = {hiWrapDn, hiWrapUp, loWrapDn, loWrapUp};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flags <= '0;
      dirUp <= 1'b1;
    end else begin
      flags <= (flags & ~strobes.clrMask) | setMask;
      if (strobes.loStep && !strobes.wrLo) dirUp <= strobes.loUp;
    end
  end

  // R2: without a load the lower counter moves by at most one per cycle
  p_step_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.wrLo) |->
      (cntLo == $past(cntLo) || cntLo == $past(cntLo) + ONE || cntLo == $past(cntLo) - ONE));

  // R6: an upward wrap carries into the upper counter on the same edge
  p_carry_up_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cascadeEn && loWrapUp && !strobes.wrHi) |=> cntHi == $past(cntHi) + ONE);

  // R6: a downward wrap borrows from the upper counter on the same edge
  p_borrow_dn_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cascadeEn && loWrapDn && !strobes.wrHi) |=> cntHi == $past(cntHi) - ONE);

  // R8: the lower overflow flag only rises together with a wrap to zero
  p_ovf_origin_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[0]) |-> ($past(cntLo) == {CNT_W{1'b1}} && cntLo == '0));

  // R10: direction holds while no lower count occurs
  p_dir_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.loStep) |-> $stable(dirUp));
endmodule

// File: rtl/quad_cascade_counter.sv
module quad_cascade_counter
  import qcc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              encA,
  input  logic              encB,
  input  logic              phaseEn,
  input  logic              cascadeEn,
  input  logic              cntStrobeLo,
  input  logic              cntStrobeHi,
  input  logic              wrEn,
  input  logic [1:0]        regSel,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  cntLo,
  output logic [CNT_W-1:0]  cntHi,
  output logic [FLAG_W-1:0] flags,
  output logic              dirUp
);
  qcc_strobe_t strobes;

  qcc_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .encA(encA), .encB(encB),
    .phaseEn(phaseEn), .cascadeEn(cascadeEn),
    .cntStrobeLo(cntStrobeLo), .cntStrobeHi(cntStrobeHi),
    .wrEn(wrEn), .regSel(regSel), .clrBits(wrData[FLAG_W-1:0]),
    .strobes(strobes)
  );

  qcc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .cascadeEn(cascadeEn), .strobes(strobes), .wrData(wrData),
    .cntLo(cntLo), .cntHi(cntHi), .flags(flags), .dirUp(dirUp)
  );
endmodule

// File: tb/quad_cascade_counter_tb.sv
module quad_cascade_counter_tb;
  logic clk = 1'b0;
  logic rstN, encA, encB, phaseEn, cascadeEn, cntStrobeLo, cntStrobeHi, wrEn;
  logic [1:0]  regSel;
  logic [15:0] wrData, cntLo, cntHi;
  logic [3:0]  flags;
  logic        dirUp;

  int checks = 0;
  int failures = 0;
  int encIdx = 0;
  logic [15:0] expLo = 0, expHi = 0;
  logic [3:0]  expFlags = 0;

  always #2 clk = ~clk;

  quad_cascade_counter u_dut (
    .clk(clk), .rstN(rstN), .encA(encA), .encB(encB),
    .phaseEn(phaseEn), .cascadeEn(cascadeEn),
    .cntStrobeLo(cntStrobeLo), .cntStrobeHi(cntStrobeHi),
    .wrEn(wrEn), .regSel(regSel), .wrData(wrData),
    .cntLo(cntLo), .cntHi(cntHi), .flags(flags), .dirUp(dirUp)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // quadrature state order 00,10,11,01 (AB)
  task automatic driveIdx(input int idx);
    encA = (idx == 1) || (idx == 2);
    encB = (idx == 2) || (idx == 3);
  endtask

  // model of one lower count in cascade mode
  task automatic modelStep(input bit up);
    if (up) begin
      if (expLo == 16'hFFFF) begin
        expFlags[0] = 1'b1;
        if (expHi == 16'hFFFF) expFlags[2] = 1'b1;
        expHi = expHi + 16'd1;
      end
      expLo = expLo + 16'd1;
    end else begin
      if (expLo == 16'h0000) begin
        expFlags[1] = 1'b1;
        if (expHi == 16'h0000) expFlags[3] = 1'b1;
        expHi = expHi - 16'd1;
      end
      expLo = expLo - 16'd1;
    end
  endtask

  task automatic encStep(input bit up);
    encIdx = up ? (encIdx + 1) % 4 : (encIdx + 3) % 4;
    driveIdx(encIdx);
    tick(3);
  endtask

  task automatic writeReg(input logic [1:0] sel, input logic [15:0] data);
    wrEn = 1'b1; regSel = sel; wrData = data;
    tick(1);
    wrEn = 1'b0; regSel = 2'd3; wrData = 16'h0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 0; encA = 0; encB = 0; phaseEn = 0; cascadeEn = 0;
    cntStrobeLo = 0; cntStrobeHi = 0; wrEn = 0; regSel = 2'd3; wrData = 0;
    tick(3);
    rstN = 1;
    tick(1);
    // R1 reset state
    chk("R1 cntLo", 32'(cntLo), 0);
    chk("R1 cntHi", 32'(cntHi), 0);
    chk("R1 flags", 32'(flags), 0);
    chk("R1 dirUp", 32'(dirUp), 1);

    phaseEn = 1; cascadeEn = 1;
    // R2 latency: two edges still old, third edge new
    encIdx = 1; driveIdx(encIdx);
    tick(2);
    chk("R2 before latency", 32'(cntLo), 0);
    tick(1);
    chk("R2 after latency", 32'(cntLo), 1);
    expLo = 1;

    // R3 R6 R10 sweep across the 32-bit boundary
    writeReg(2'd0, 16'hFFF8); expLo = 16'hFFF8;
    writeReg(2'd1, 16'h0005); expHi = 16'h0005;
    chk("R9 load pair", {cntHi, cntLo}, 32'h0005FFF8);
    for (int i = 0; i < 60; i++) begin
      bit up;
      up = (i < 20) || (i >= 40);
      if (i % 7 == 6) up = !up;
      encStep(up); modelStep(up);
      chk(up ? "R2 R6 up step" : "R3 R6 down step", {cntHi, cntLo}, {expHi, expLo});
      chk("R10 direction", 32'(dirUp), 32'(up));
    end
    chk("R8 lower flags", 32'(flags), 32'(expFlags));
    writeReg(2'd2, 16'h000F); expFlags = 0;
    chk("R8 cleared", 32'(flags), 0);

    // R4 double change ignored
    encIdx = (encIdx + 2) % 4; driveIdx(encIdx);
    tick(4);
    chk("R4 lo unchanged", {cntHi, cntLo}, {expHi, expLo});
    chk("R4 flags unchanged", 32'(flags), 0);
    encStep(0); modelStep(0);
    chk("R4 next legal step", {cntHi, cntLo}, {expHi, expLo});
    chk("R4 dir after", 32'(dirUp), 0);

    // R8 upper flags via cascade wrap
    writeReg(2'd0, 16'hFFFF); expLo = 16'hFFFF;
    writeReg(2'd1, 16'hFFFF); expHi = 16'hFFFF;
    encStep(1); modelStep(1);
    chk("R6 R8 full wrap up", {cntHi, cntLo}, 32'h0);
    chk("R8 up flags", 32'(flags), 32'h5);
    encStep(0); modelStep(0);
    chk("R6 R8 full wrap down", {cntHi, cntLo}, 32'hFFFFFFFF);
    chk("R8 all flags", 32'(flags), 32'hF);
    writeReg(2'd2, 16'h0005);
    chk("R8 partial clear", 32'(flags), 32'hA);
    writeReg(2'd3, 16'h1234);
    chk("R9 sel3 no effect", {cntHi, cntLo}, 32'hFFFFFFFF);
    writeReg(2'd2, 16'h000F);

    // R5 encoder ignored with decoding off
    phaseEn = 0;
    for (int k = 0; k < 4; k++) begin
      encIdx = (encIdx + 1) % 4; driveIdx(encIdx); tick(4);
      chk("R5 encoder ignored", 32'(cntLo), 32'hFFFF);
    end
    // R9 write beats strobe count
    wrEn = 1; regSel = 2'd0; wrData = 16'h1234; cntStrobeLo = 1;
    tick(1);
    wrEn = 0; regSel = 2'd3; wrData = 0; cntStrobeLo = 0;
    chk("R9 write priority", 32'(cntLo), 32'h1234);
    cntStrobeLo = 1; tick(5); cntStrobeLo = 0; tick(1);
    chk("R5 strobe count", 32'(cntLo), 32'h1239);
    chk("R10 strobe is up", 32'(dirUp), 1);
    phaseEn = 1; tick(4);
    chk("R5 no spurious count", 32'(cntLo), 32'h1239);
    encStep(0);
    chk("R5 decode resumes", 32'(cntLo), 32'h1238);

    // R7 independent upper channel
    cascadeEn = 0; phaseEn = 0;
    writeReg(2'd0, 16'hFFFF);
    writeReg(2'd1, 16'h0010);
    cntStrobeLo = 1; tick(1); cntStrobeLo = 0; tick(1);
    chk("R7 lo wraps", 32'(cntLo), 0);
    chk("R7 hi untouched", 32'(cntHi), 32'h10);
    chk("R8 lo ovf only", 32'(flags), 32'h1);
    cntStrobeHi = 1; tick(3); cntStrobeHi = 0; tick(1);
    chk("R7 hi strobe count", 32'(cntHi), 32'h13);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule